// File: doc/BRIEF.md
# NTSC Composite Video Sample Generator

This block turns a stream of palette indices into a 5-bit composite NTSC sample stream for an external resistor-ladder DAC, where code 0 is the lowest voltage. It runs from a clock of exactly eight times the color subcarrier (315/88 MHz × 8, about 28.636 MHz). Each output sample is therefore one eighth of a subcarrier cycle. The block produces horizontal sync, broad vertical sync pulses, the color burst, blanking and a 256 × 240 active picture. It runs progressive at 262 lines per field, which is a field rate of about 60 Hz.

Pixel data is pulled rather than pushed. One clock before a pixel is shown, the block raises a request strobe with the pixel's column and row. The client answers in that same cycle with a 6-bit palette index. A mode input selects how the index is read. In one mode it picks one of 16 built-in colors. In the other it is taken directly as a 2-bit red, green and blue triple. In both modes the color becomes a luma level plus a chroma amplitude and phase. The chroma is added as an 8-step sine that follows a free-running subcarrier phase counter, and the sum is saturated into the DAC range.

Top module: `ntsc_composite_gen`

## Requirements
- R1: Position counting. After reset is released, the first clock is column 0 of line 0. A line is 1820 clocks (columns 0..1819), and a field is FIELD_LINES lines (default 262), progressive. The column after 1819 is column 0 of the next line, and the line after the last is line 0.
- R2: While rst_n is low, dac_out is 6 and pix_req is 0.
- R3: On lines that are not vertical-sync lines, dac_out is 0 for columns 0..133. Every dac_out value is the sample for the position of the previous clock.
- R4: Lines VS_START to VS_START+2 (default 3..5) are vertical-sync lines. On them dac_out is 0 for columns 0..1685 and 6 for columns 1686..1819, with no burst.
- R5: On lines that are not vertical-sync lines, columns 150..221 (nine subcarrier cycles) carry burst: 6 + B[(s+4) mod 8], where B = (0,3,4,3,0,-3,-4,-3). Here s is the subcarrier phase, equal to the number of clocks since reset release, mod 8. Because 1820 mod 8 = 4, s at column 0 alternates between 0 and 4 on successive lines.
- R6: On active lines V_START..V_START+V_ACTIVE-1 (default 20..259), pix_req is high for exactly one clock, at column 369 + 5x, for x = 0..255. In that clock pix_x = x and pix_y = line − V_START. On every other clock pix_req is 0.
- R7: pix_index is captured only in a clock where pix_req is high. That value is used for the five samples at columns 370+5x..374+5x. An index presented while pix_req is low has no effect on the output.
- R8: With pal_sel = 0 (built-in mode), only pix_index[3:0] = k is used and bits 5:4 are ignored. If k[3] = 0, the color is a gray with luma 8 + floor(20·k/7) (black 8 to white 28) and amplitude 0. If k[3] = 1, luma is 16, amplitude is 3 and phase is k[2:0].
- R9: With pal_sel = 1 (direct mode), pix_index = {r[1:0], g[1:0], b[1:0]}. Luma is 8 + 2r + 3g + b, and amplitude is max(r,g,b) − min(r,g,b). The phase comes from the key {r≥g, g≥b, b≥r}: 000→0, 001→5, 010→2, 011→3, 100→0, 101→6, 110→1, 111→0.
- R10: At active-line columns 370..1649, dac_out = clamp(L + A·S[(s+P) mod 8], 0, 31), where S = (0,2,3,2,0,-2,-3,-2). L, A and P are the luma, amplitude and phase of the held index.
- R11: Every position not covered by R3, R4, R5 or R10 gives the blanking level 6.
- R12: pal_sel is read when each sample is formed, not when the index is captured. A change therefore affects the very next sample, even in the middle of a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 8 × color subcarrier |
| rst_n | input | 1 | Synchronous active-low reset |
| pal_sel | input | 1 | Palette mode: 0 built-in 16 colors, 1 direct rrggbb |
| pix_req | output | 1 | Pixel request strobe, one clock ahead of use |
| pix_x | output | XW (8) | Column of the requested pixel |
| pix_y | output | YW (8) | Row of the requested pixel |
| pix_index | input | 6 | Palette index answering the request in the same clock |
| dac_out | output | 5 | Composite sample code for the ladder DAC |

## Verification
The hardest case to reach from the ports is the interaction of three behaviours: the half-cycle line phase, the saturation of bright saturated colors, and a mode change that lands in the middle of a pixel. Each needs a particular line parity, index and timing at the same time, and a full field is far too long to run several times. The bench therefore overrides the vertical parameters to a 12-line field with four active lines. It feeds indices that sweep all 64 codes across columns and rows, and drives noise onto the index whenever no request is pending. In the third field it toggles the mode every 611 clocks, a period prime to both the pixel and the subcarrier periods, so the switches fall at every pixel offset and subcarrier phase.

// File: rtl/ntsc_pkg.sv
// Shared types and colour arithmetic for the composite NTSC generator.
// Assumes an 8-step subcarrier phase (clock = 8 x subcarrier).
package ntsc_pkg;

    localparam int IDX_W = 6;

    typedef enum logic [1:0] {
        RG_BLANK,
        RG_SYNC,
        RG_BURST,
        RG_PIXEL
    } region_t;

    typedef struct packed {
        logic [4:0] luma;
        logic [1:0] amp;
        logic [2:0] phase;
    } color_t;

    localparam logic [4:0] LVL_SYNC  = 5'd0;
    localparam logic [4:0] LVL_BLANK = 5'd6;

    // Signed chroma sine, 8 steps per subcarrier cycle.
    function automatic logic signed [2:0] sin_step(input logic [2:0] ph);
        case (ph)
            3'd1, 3'd3: sin_step = 3'sd2;
            3'd2:       sin_step = 3'sd3;
            3'd5, 3'd7: sin_step = -3'sd2;
            3'd6:       sin_step = -3'sd3;
            default:    sin_step = 3'sd0;
        endcase
    endfunction

    // Signed burst waveform, +/-4 codes.
    function automatic logic signed [3:0] burst_step(input logic [2:0] ph);
        case (ph)
            3'd1, 3'd3: burst_step = 4'sd3;
            3'd2:       burst_step = 4'sd4;
            3'd5, 3'd7: burst_step = -4'sd3;
            3'd6:       burst_step = -4'sd4;
            default:    burst_step = 4'sd0;
        endcase
    endfunction

    // Built-in 16-entry palette: 8 grays, then 8 hues at fixed luma.
    function automatic color_t fixed_color(input logic [3:0] k);
        color_t c;
        c.phase = k[2:0];
        if (k[3]) begin
            c.luma = 5'd16;
            c.amp  = 2'd3;
        end else begin
            c.amp   = 2'd0;
            c.phase = 3'd0;
            case (k[2:0])
                3'd0: c.luma = 5'd8;
                3'd1: c.luma = 5'd10;
                3'd2: c.luma = 5'd13;
                3'd3: c.luma = 5'd16;
                3'd4: c.luma = 5'd19;
                3'd5: c.luma = 5'd22;
                3'd6: c.luma = 5'd25;
                default: c.luma = 5'd28;
            endcase
        end
        return c;
    endfunction

    // Direct rrggbb colour: weighted luma, spread as amplitude, hue key as phase.
    function automatic color_t rgb_color(input logic [5:0] v);
        color_t c;
        logic [1:0] r, g, b, mx, mn;
        r  = v[5:4];
        g  = v[3:2];
        b  = v[1:0];
        mx = (r >= g) ? ((r >= b) ? r : b) : ((g >= b) ? g : b);
        mn = (r <= g) ? ((r <= b) ? r : b) : ((g <= b) ? g : b);
        c.luma = 5'd8 + 5'({r, 1'b0}) + 5'({g, 1'b0}) + 5'(g) + 5'(b);
        c.amp  = mx - mn;
        case ({r >= g, g >= b, b >= r})
            3'b001:  c.phase = 3'd5;
            3'b010:  c.phase = 3'd2;
            3'b011:  c.phase = 3'd3;
            3'b101:  c.phase = 3'd6;
            3'b110:  c.phase = 3'd1;
            default: c.phase = 3'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ntsc_timing.sv
// Raster timing: column, line and subcarrier-phase counters, region
// classification and the pixel request strobe issued one clock early.
// Assumes ACT_START >= 2 and PIX_CLKS >= 2.
module ntsc_timing
    import ntsc_pkg::*;
#(
    parameter int LINE_CLKS    = 1820,
    parameter int HSYNC_CLKS   = 134,
    parameter int BURST_START  = 150,
    parameter int BURST_CYCLES = 9,
    parameter int ACT_START    = 370,
    parameter int PIX_CLKS     = 5,
    parameter int H_ACTIVE     = 256,
    parameter int FIELD_LINES  = 262,
    parameter int VS_START     = 3,
    parameter int VS_LINES     = 3,
    parameter int V_START      = 20,
    parameter int V_ACTIVE     = 240,
    parameter int XW           = $clog2(H_ACTIVE),
    parameter int YW           = $clog2(V_ACTIVE)
) (
    input  logic          clk,
    input  logic          rst_n,
    output region_t       region,
    output logic [2:0]    sc_phase,
    output logic          pix_req,
    output logic [XW-1:0] pix_x,
    output logic [YW-1:0] pix_y
);

    localparam int HW = $clog2(LINE_CLKS);
    localparam int VW = $clog2(FIELD_LINES);
    localparam int PW = $clog2(PIX_CLKS);
    localparam logic [HW-1:0] H_LAST    = HW'(LINE_CLKS - 1);
    localparam logic [HW-1:0] HS_END    = HW'(HSYNC_CLKS);
    localparam logic [HW-1:0] BR_BEGIN  = HW'(BURST_START);
    localparam logic [HW-1:0] BR_END    = HW'(BURST_START + BURST_CYCLES * 8);
    localparam logic [HW-1:0] ACT_BEGIN = HW'(ACT_START);
    localparam logic [HW-1:0] ACT_END   = HW'(ACT_START + H_ACTIVE * PIX_CLKS);
    localparam logic [HW-1:0] REQ_BEGIN = HW'(ACT_START - 1);
    localparam logic [HW-1:0] REQ_PRE   = HW'(ACT_START - 2);
    localparam logic [HW-1:0] REQ_END   = HW'(ACT_START - 1 + H_ACTIVE * PIX_CLKS);
    localparam logic [HW-1:0] BROAD_END = HW'(LINE_CLKS - HSYNC_CLKS);
    localparam logic [VW-1:0] V_LAST    = VW'(FIELD_LINES - 1);
    localparam logic [VW-1:0] VS_BEGIN  = VW'(VS_START);
    localparam logic [VW-1:0] VS_END    = VW'(VS_START + VS_LINES);
    localparam logic [VW-1:0] VA_BEGIN  = VW'(V_START);
    localparam logic [VW-1:0] VA_END    = VW'(V_START + V_ACTIVE);
    localparam logic [PW-1:0] SUB_LAST  = PW'(PIX_CLKS - 1);

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic [2:0]    sc_cnt;
    logic [PW-1:0] sub_cnt;
    logic [XW-1:0] x_cnt;
    logic          vs_line, act_line;

    // Column, line and subcarrier counters advance every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt  <= '0;
            v_cnt  <= '0;
            sc_cnt <= '0;
        end else begin
            sc_cnt <= sc_cnt + 3'd1;
            if (h_cnt == H_LAST) begin
                h_cnt <= '0;
                v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + VW'(1);
            end else begin
                h_cnt <= h_cnt + HW'(1);
            end
        end
    end

    // Pixel sub-clock and column counters, realigned just before each request window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_cnt <= '0;
            x_cnt   <= '0;
        end else if (h_cnt == REQ_PRE) begin
            sub_cnt <= '0;
            x_cnt   <= '0;
        end else begin
            sub_cnt <= (sub_cnt == SUB_LAST) ? '0 : sub_cnt + PW'(1);
            if (pix_req) x_cnt <= x_cnt + XW'(1);
        end
    end

    // Line classification.
    always_comb begin
        vs_line  = (v_cnt >= VS_BEGIN) && (v_cnt < VS_END);
        act_line = (v_cnt >= VA_BEGIN) && (v_cnt < VA_END);
    end

    // Region of the current position.
    always_comb begin
        if (vs_line)
            region = (h_cnt < BROAD_END) ? RG_SYNC : RG_BLANK;
        else if (h_cnt < HS_END)
            region = RG_SYNC;
        else if (h_cnt >= BR_BEGIN && h_cnt < BR_END)
            region = RG_BURST;
        else if (act_line && h_cnt >= ACT_BEGIN && h_cnt < ACT_END)
            region = RG_PIXEL;
        else
            region = RG_BLANK;
    end

    // Request strobe and its coordinates.
    always_comb begin
        pix_req  = act_line && (h_cnt >= REQ_BEGIN) && (h_cnt < REQ_END) && (sub_cnt == '0);
        pix_x    = x_cnt;
        pix_y    = YW'(v_cnt - VA_BEGIN);
        sc_phase = sc_cnt;
    end

    a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt == H_LAST) |=> (h_cnt == '0));

    a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> !pix_req);

    a_r6_req_precedes_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> (region == RG_PIXEL));

    a_r4_no_burst_in_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        vs_line |-> (region != RG_BURST));

    // Line-start subcarrier phase flips by half a cycle when a line holds a half cycle.
    generate
        if (LINE_CLKS % 8 == 4) begin : g_phase_check
            logic [2:0] sc_at_start;
            logic       seen_start;
            // Remember the phase at the previous line start.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sc_at_start <= '0;
                    seen_start  <= 1'b0;
                end else if (h_cnt == '0) begin
                    sc_at_start <= sc_cnt;
                    seen_start  <= 1'b1;
                end
            end
            a_r5_line_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
                (h_cnt == '0 && seen_start) |-> (sc_cnt == sc_at_start + 3'd4));
        end
    endgenerate

endmodule

// File: rtl/ntsc_palette.sv
// Palette decode: maps a 6-bit index to luma, chroma amplitude and phase.
// Mode 0 uses the built-in 16 entries (low nibble); mode 1 reads rrggbb.
module ntsc_palette
    import ntsc_pkg::*;
(
    input  logic [IDX_W-1:0] index,
    input  logic             direct_mode,
    output color_t           color
);

    // Select the decode for the current mode.
    always_comb begin
        if (direct_mode)
            color = rgb_color(index);
        else
            color = fixed_color(index[3:0]);
    end

endmodule

// File: rtl/ntsc_mixer.sv
// Sample former: holds the requested index, decodes it with the current
// palette mode, adds modulated chroma and registers the DAC code.
// Assumes region and sc_phase describe the current clock's position.
module ntsc_mixer
    import ntsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  region_t          region,
    input  logic [2:0]       sc_phase,
    input  logic             pix_req,
    input  logic [IDX_W-1:0] pix_index,
    input  logic             pal_sel,
    output logic [4:0]       dac_out
);

    logic [IDX_W-1:0]   pix_reg;
    color_t             color;
    logic signed [7:0]  amp_s, step_s, chroma, sum;
    logic signed [7:0]  burst_sum;
    logic [4:0]         pixel_code, next_code;

    ntsc_palette u_palette (
        .index       (pix_index_held()),
        .direct_mode (pal_sel),
        .color       (color)
    );

    function automatic logic [IDX_W-1:0] pix_index_held();
        return pix_reg;
    endfunction

    // Capture the index only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_reg <= '0;
        else if (pix_req) pix_reg <= pix_index;
    end

    // Luma plus chroma, saturated into the DAC range.
    always_comb begin
        amp_s  = $signed({6'b000000, color.amp});
        step_s = 8'(sin_step(sc_phase + color.phase));
        chroma = amp_s * step_s;
        sum    = $signed({3'b000, color.luma}) + chroma;
        if (sum < 0)
            pixel_code = 5'd0;
        else if (sum > 8'sd31)
            pixel_code = 5'd31;
        else
            pixel_code = sum[4:0];
        burst_sum = $signed({3'b000, LVL_BLANK}) + 8'(burst_step(sc_phase + 3'd4));
    end

    // Choose the code for the current region.
    always_comb begin
        case (region)
            RG_SYNC:  next_code = LVL_SYNC;
            RG_BURST: next_code = burst_sum[4:0];
            RG_PIXEL: next_code = pixel_code;
            default:  next_code = LVL_BLANK;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) dac_out <= LVL_BLANK;
        else        dac_out <= next_code;
    end

    a_r3_sync_level: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_SYNC) |=> (dac_out == 5'd0));

    a_r11_blank_level: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_BLANK) |=> (dac_out == 5'd6));

    a_r5_burst_band: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_BURST) |=> (dac_out >= 5'd2 && dac_out <= 5'd10));

    a_r7_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_req |=> $stable(pix_reg));

endmodule

// File: rtl/ntsc_composite_gen.sv
// Composite NTSC generator top: raster timing feeding the sample former.
// Assumes clk = 8 x colour subcarrier and an index answer in the request cycle.
module ntsc_composite_gen #(
    parameter int LINE_CLKS    = 1820,
    parameter int HSYNC_CLKS   = 134,
    parameter int BURST_START  = 150,
    parameter int BURST_CYCLES = 9,
    parameter int ACT_START    = 370,
    parameter int PIX_CLKS     = 5,
    parameter int H_ACTIVE     = 256,
    parameter int FIELD_LINES  = 262,
    parameter int VS_START     = 3,
    parameter int VS_LINES     = 3,
    parameter int V_START      = 20,
    parameter int V_ACTIVE     = 240,
    parameter int XW           = $clog2(H_ACTIVE),
    parameter int YW           = $clog2(V_ACTIVE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pal_sel,
    output logic          pix_req,
    output logic [XW-1:0] pix_x,
    output logic [YW-1:0] pix_y,
    input  logic [5:0]    pix_index,
    output logic [4:0]    dac_out
);

    ntsc_pkg::region_t region;
    logic [2:0]        sc_phase;

    ntsc_timing #(
        .LINE_CLKS    (LINE_CLKS),
        .HSYNC_CLKS   (HSYNC_CLKS),
        .BURST_START  (BURST_START),
        .BURST_CYCLES (BURST_CYCLES),
        .ACT_START    (ACT_START),
        .PIX_CLKS     (PIX_CLKS),
        .H_ACTIVE     (H_ACTIVE),
        .FIELD_LINES  (FIELD_LINES),
        .VS_START     (VS_START),
        .VS_LINES     (VS_LINES),
        .V_START      (V_START),
        .V_ACTIVE     (V_ACTIVE),
        .XW           (XW),
        .YW           (YW)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .region   (region),
        .sc_phase (sc_phase),
        .pix_req  (pix_req),
        .pix_x    (pix_x),
        .pix_y    (pix_y)
    );

    ntsc_mixer u_mixer (
        .clk       (clk),
        .rst_n     (rst_n),
        .region    (region),
        .sc_phase  (sc_phase),
        .pix_req   (pix_req),
        .pix_index (pix_index),
        .pal_sel   (pal_sel),
        .dac_out   (dac_out)
    );

endmodule

// File: tb/tb_ntsc_composite_gen.sv
module tb_ntsc_composite_gen;

    localparam int LINES = 12, VSS = 3, VSL = 3, VST = 6, VACT = 4;
    localparam int LINE = 1820, HS = 134, BST = 150, BEND = 222;
    localparam int AST = 370, PIX = 5, HACT = 256;
    localparam int XW = 8, YW = 2;
    localparam int FIELD = LINE * LINES;
    localparam int TOTAL = 3 * FIELD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pal_sel = 1'b0;
    logic          pix_req;
    logic [XW-1:0] pix_x;
    logic [YW-1:0] pix_y;
    logic [5:0]    pix_index = '0;
    logic [4:0]    dac_out;

    always #5 clk = ~clk;

    ntsc_composite_gen #(
        .FIELD_LINES (LINES),
        .VS_START    (VSS),
        .VS_LINES    (VSL),
        .V_START     (VST),
        .V_ACTIVE    (VACT),
        .XW          (XW),
        .YW          (YW)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pal_sel   (pal_sel),
        .pix_req   (pix_req),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pix_index (pix_index),
        .dac_out   (dac_out)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sine_tab(input int i);
        int t[8] = '{0, 2, 3, 2, 0, -2, -3, -2};
        return t[i % 8];
    endfunction

    function automatic int burst_tab(input int i);
        int t[8] = '{0, 3, 4, 3, 0, -3, -4, -3};
        return t[i % 8];
    endfunction

    // Palette rules of R8 and R9.
    function automatic void decode(input int idx, input int mode,
                                   output int l, output int a, output int p);
        if (mode == 0) begin
            int k = idx % 16;
            if (k >= 8) begin l = 16; a = 3; p = k - 8; end
            else begin l = 8 + (20 * k) / 7; a = 0; p = 0; end
        end else begin
            int r = (idx / 16) % 4, g = (idx / 4) % 4, b = idx % 4;
            int mx = r, mn = r, key;
            if (g > mx) mx = g;
            if (b > mx) mx = b;
            if (g < mn) mn = g;
            if (b < mn) mn = b;
            l = 8 + 2 * r + 3 * g + b;
            a = mx - mn;
            key = (r >= g ? 4 : 0) + (g >= b ? 2 : 0) + (b >= r ? 1 : 0);
            case (key)
                1: p = 5;
                2: p = 2;
                3: p = 3;
                5: p = 6;
                6: p = 1;
                default: p = 0;
            endcase
        end
    endfunction

    // Expected sample for a position (R3, R4, R5, R10, R11).
    function automatic int sample(input int h, input int v, input int sc,
                                  input int mode, input int idx, input int fld,
                                  output string tag);
        bit vs  = (v >= VSS) && (v < VSS + VSL);
        bit act = (v >= VST) && (v < VST + VACT);
        if (vs) begin
            tag = "R4";
            return (h < LINE - HS) ? 0 : 6;
        end
        if (h < HS) begin
            tag = (h == 0) ? "R1 R3" : "R3";
            return 0;
        end
        if (h >= BST && h < BEND) begin
            tag = "R5";
            return 6 + burst_tab(sc + 4);
        end
        if (act && h >= AST && h < AST + HACT * PIX) begin
            int l, a, p, s;
            decode(idx, mode, l, a, p);
            s = l + a * sine_tab(sc + p);
            if (s < 0) s = 0;
            if (s > 31) s = 31;
            tag = (mode == 0) ? "R7 R8 R10" : "R7 R9 R10";
            if (fld == 2) tag = {tag, " R12"};
            return s;
        end
        tag = "R11";
        return 6;
    endfunction

    initial begin
        int h = 0, v = 0, held = 0, exp_val = 0;
        bit exp_ok = 0;
        string exp_tag = "";
        repeat (3) begin
            @(negedge clk);
            check("R2 reset dac_out", int'(dac_out), 6);
            check("R2 reset pix_req", int'(pix_req), 0);
        end
        for (int step = 0; step <= TOTAL; step++) begin
            int fld = step / FIELD;
            int mode, mx, my, idx;
            bit act, mreq;
            @(negedge clk);
            if (step == 0) rst_n = 1'b1;
            if (exp_ok)
                check($sformatf("%s dac_out at step %0d", exp_tag, step - 1),
                      int'(dac_out), exp_val);
            if (step == TOTAL) break;
            mode = (fld == 0) ? 0 : (fld == 1) ? 1 : (step / 611) % 2;
            pal_sel = mode[0];
            act  = (v >= VST) && (v < VST + VACT);
            mreq = act && (h >= AST - 1) && (h < AST - 1 + HACT * PIX)
                   && ((h - (AST - 1)) % PIX == 0);
            mx = (h - (AST - 1)) / PIX;
            my = v - VST;
            check($sformatf("R6 pix_req h=%0d v=%0d", h, v), int'(pix_req), int'(mreq));
            if (mreq) begin
                check("R6 pix_x", int'(pix_x), mx);
                check("R6 pix_y", int'(pix_y), my);
                idx = (mx + 7 * my + 13 * fld) % 64;
            end else begin
                idx = (step * 37 + 11) % 64;
            end
            pix_index = idx[5:0];
            exp_val = sample(h, v, step % 8, mode, held, fld, exp_tag);
            exp_ok  = 1;
            if (mreq) held = idx;
            h++;
            if (h == LINE) begin
                h = 0;
                v = (v == LINES - 1) ? 0 : v + 1;
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (TOTAL + 5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule